// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This host-side controller takes over once a program or erase command has been sent to a flash device. A single start pulse supplies three things: the polling method, the status-configuration mode the device was set to, and the data word that was written. From then on the block repeatedly reads the device over a simple request/acknowledge read port. It judges completion and failure from status bits 7, 6 and 5 of each word it reads.

Two polling methods are supported. In data polling, the block watches bit 7. In toggle polling, it compares bit 6 across back-to-back reads. A bit 5 seen while the device still looks busy is not trusted on its own: the block makes one confirming read first.

The block ends in one of three results: success, failure or timeout. On failure, and also after success in the exit-always mode, it writes the exit command through a request/acknowledge write port before it raises its result. The result stays up until the next start.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While rst_ni is low, and after reset until a start, rd_req_o, wr_req_o, busy_o, done_ok_o, done_fail_o and timeout_o are all 0.
- R2: A start_i pulse is accepted only when the block is not busy. It latches method_i (0 = data polling, 1 = toggle polling), cfg_i (0 = auto-return mode, 1 = exit-always mode) and exp_data_i, and clears the result. rd_req_o is high from the very next cycle, with no initial wait. A start_i while busy_o is 1 has no effect on the operation in progress.
- R3: rd_req_o stays high until a cycle with rd_ack_i high. The word on rd_data_i in that cycle is the one evaluated. rd_req_o and wr_req_o are never high together.
- R4: In data polling with cfg_i=0, completion is a read whose bit 7 equals bit 7 of the expected data. The result is success, with no exit write, if the whole word equals the expected data. Otherwise the result is failure.
- R5: In data polling with cfg_i=1, completion is a read with bit 7 = 1. That read's bit 5 then decides the result: 1 gives failure, 0 gives success. An exit write follows in both cases.
- R6: In toggle polling, completion is two consecutive reads with the same bit 6, and the result is success. An exit write follows only when cfg_i=1.
- R7: A bit 5 = 1 on a read that does not show completion triggers exactly one more read. Failure is declared only if that read also shows bit 5 = 1 without completion. If it completes instead, the normal result applies.
- R8: On failure the block writes EXIT_CMD (default 0x00F0) through the write handshake. done_fail_o rises only after wr_ack_i.
- R9: After MAX_READS reads without completion or confirmed failure, the result is timeout and no exit write is made. A completion on the last permitted read still counts as completion. The block never makes more than MAX_READS reads per start.
- R10: At most one of done_ok_o, done_fail_o and timeout_o is high. The result is held until the next accepted start, which clears it in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| method_i | input | 1 | 0 data polling, 1 toggle polling |
| cfg_i | input | 1 | 0 auto-return mode, 1 exit-always mode |
| exp_data_i | input | DW | Data word that was programmed |
| rd_req_o | output | 1 | Read request |
| rd_ack_i | input | 1 | Read acknowledge, rd_data_i valid |
| rd_data_i | input | DW | Word read from the device |
| wr_req_o | output | 1 | Write request for the exit command |
| wr_ack_i | input | 1 | Write acknowledge |
| wr_data_o | output | DW | Exit command word |
| busy_o | output | 1 | Polling or exit write in progress |
| done_ok_o | output | 1 | Operation completed successfully |
| done_fail_o | output | 1 | Operation failed |
| timeout_o | output | 1 | Read limit reached without completion |

## Verification
A wrong evaluation state appears within one read cycle. It shows up as the wrong number of reads per start, which the bench counts against a hand-derived figure, or as a missing or extra exit write. A wrong toggle history or a lost bit 5 confirmation flag changes the read count by at least one. A wrong latched mode flips the result flag or the write count once the operation settles. Scenarios sit on the timeout boundary, on the single-read bit 5 glitch, and on a start issued mid-poll, so off-by-one counting and unwanted restarts show up as an exact read-count mismatch.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int unsigned B_POLL = 7;
  localparam int unsigned B_TOG  = 6;
  localparam int unsigned B_ERR  = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ1, ST_READ2, ST_EVAL, ST_EXIT_WR, ST_DONE
  } state_e;

  typedef enum logic [1:0] {
    RES_NONE, RES_OK, RES_FAIL, RES_TMO
  } res_e;
endpackage

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
  import flash_poll_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          method_i,
  input  logic          cfg_i,
  input  logic [DW-1:0] exp_i,
  input  logic [DW-1:0] cur_i,
  input  logic          prev_tog_i,
  output logic          done_o,
  output logic          fail_o,
  output logic          err_o
);
  logic dp_done, tg_done, dp_bad;

  always_comb begin
    dp_done = cfg_i ? cur_i[B_POLL] : (cur_i[B_POLL] == exp_i[B_POLL]);
    tg_done = (cur_i[B_TOG] == prev_tog_i);
    dp_bad  = cfg_i ? cur_i[B_ERR] : (cur_i != exp_i);
    done_o  = method_i ? tg_done : dp_done;
    fail_o  = done_o && !method_i && dp_bad;
    err_o   = cur_i[B_ERR];
  end
endmodule

// File: rtl/flash_poll_cnt.sv
module flash_poll_cnt #(
  parameter int unsigned MAX = 64,
  localparam int unsigned CW = $clog2(MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          at_max_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !at_max_o) cnt_q <= cnt_q + 1'b1;
  end

  assign at_max_o = (cnt_q >= CW'(MAX));
  assign cnt_o    = cnt_q;

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(MAX));
  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import flash_poll_pkg::*;
#(
  parameter int unsigned    DW        = 16,
  parameter int unsigned    MAX_READS = 64,
  parameter logic [DW-1:0]  EXIT_CMD  = DW'(16'h00F0),
  localparam int unsigned   CW        = $clog2(MAX_READS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          method_i,
  input  logic          cfg_i,
  input  logic [DW-1:0] exp_data_i,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_req_o,
  input  logic          wr_ack_i,
  output logic [DW-1:0] wr_data_o,
  output logic          busy_o,
  output logic          done_ok_o,
  output logic          done_fail_o,
  output logic          timeout_o
);
  state_e        state_q, state_d;
  res_e          res_q, res_d;
  logic          method_q, cfg_q;
  logic [DW-1:0] exp_q, cur_q;
  logic          prev_tog_q, err_seen_q, err_seen_d;
  logic          accept, rd_fire;
  logic          ev_done, ev_fail, ev_err;
  logic [CW-1:0] rd_cnt;
  logic          at_max;

  assign accept  = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign rd_fire = rd_req_o && rd_ack_i;

  flash_poll_eval #(.DW(DW)) u_eval (
    .method_i   (method_q),
    .cfg_i      (cfg_q),
    .exp_i      (exp_q),
    .cur_i      (cur_q),
    .prev_tog_i (prev_tog_q),
    .done_o     (ev_done),
    .fail_o     (ev_fail),
    .err_o      (ev_err)
  );

  flash_poll_cnt #(.MAX(MAX_READS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .inc_i    (rd_fire),
    .cnt_o    (rd_cnt),
    .at_max_o (at_max)
  );

  always_comb begin
    state_d    = state_q;
    res_d      = res_q;
    err_seen_d = err_seen_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          state_d    = ST_READ1;
          res_d      = RES_NONE;
          err_seen_d = 1'b0;
        end
      end
      ST_READ1: if (rd_ack_i) state_d = method_q ? ST_READ2 : ST_EVAL;
      ST_READ2: if (rd_ack_i) state_d = ST_EVAL;
      ST_EVAL: begin
        if (ev_done) begin
          res_d   = ev_fail ? RES_FAIL : RES_OK;
          state_d = (ev_fail || cfg_q) ? ST_EXIT_WR : ST_DONE;
        end else if (ev_err && err_seen_q) begin
          res_d   = RES_FAIL;
          state_d = ST_EXIT_WR;
        end else if (at_max) begin
          res_d   = RES_TMO;
          state_d = ST_DONE;
        end else begin
          // a lone bit 5 earns one confirming read
          err_seen_d = ev_err;
          state_d    = method_q ? ST_READ2 : ST_READ1;
        end
      end
      ST_EXIT_WR: if (wr_ack_i) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      res_q      <= RES_NONE;
      err_seen_q <= 1'b0;
      method_q   <= 1'b0;
      cfg_q      <= 1'b0;
      exp_q      <= '0;
      cur_q      <= '0;
      prev_tog_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      res_q      <= res_d;
      err_seen_q <= err_seen_d;
      if (accept) begin
        method_q <= method_i;
        cfg_q    <= cfg_i;
        exp_q    <= exp_data_i;
      end
      if (rd_fire) begin
        if (state_q == ST_READ1 && method_q) prev_tog_q <= rd_data_i[B_TOG];
        else                                  cur_q      <= rd_data_i;
      end
      if (state_q == ST_EVAL && state_d == ST_READ2) prev_tog_q <= cur_q[B_TOG];
    end
  end

  assign rd_req_o    = (state_q == ST_READ1) || (state_q == ST_READ2);
  assign wr_req_o    = (state_q == ST_EXIT_WR);
  assign wr_data_o   = EXIT_CMD;
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done_ok_o   = (state_q == ST_DONE) && (res_q == RES_OK);
  assign done_fail_o = (state_q == ST_DONE) && (res_q == RES_FAIL);
  assign timeout_o   = (state_q == ST_DONE) && (res_q == RES_TMO);

  // R2
  start_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rd_req_o && !busy_o == 1'b0);
  // R3
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o);
  // R3
  no_bus_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
  // R8
  fail_after_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_fail_o) |-> $past(wr_req_o && wr_ack_i));
  // R9
  tmo_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !$past(wr_req_o));
  // R10
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_ok_o, done_fail_o, timeout_o}));
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_ok_o || done_fail_o || timeout_o) && !start_i
    |=> $stable({done_ok_o, done_fail_o, timeout_o}));
endmodule

// File: tb/flash_poll_ctrl_test.sv
module flash_poll_ctrl_test;
  localparam int unsigned DW = 16;
  localparam int unsigned MR = 8;
  localparam logic [15:0] EXPW = 16'h00A5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, method = 1'b0, cfg = 1'b0;
  logic [DW-1:0] exp_data = EXPW;
  logic rd_req, wr_req, busy, d_ok, d_fail, d_tmo;
  logic rd_ack = 1'b0, wr_ack = 1'b0;
  logic [DW-1:0] rd_data = '0, wr_data;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.DW(DW), .MAX_READS(MR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .method_i(method), .cfg_i(cfg),
    .exp_data_i(exp_data), .rd_req_o(rd_req), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .wr_req_o(wr_req), .wr_ack_i(wr_ack), .wr_data_o(wr_data), .busy_o(busy),
    .done_ok_o(d_ok), .done_fail_o(d_fail), .timeout_o(d_tmo));

  // device model parameters for the current scenario
  int nbusy = 0, b5lo = 255, b5hi = 0;
  logic [15:0] fin = EXPW;
  logic stall = 1'b0;
  int base = 0;
  int rd_cnt = 0, wr_cnt = 0, bad_wr = 0;

  function automatic logic [15:0] dev_word(int k);
    logic [15:0] w;
    if (k < nbusy) begin
      w = 16'h0000;
      w[7] = cfg ? 1'b0 : ~exp_data[7];
      w[6] = k[0];
      w[5] = (k >= b5lo) && (k <= b5hi);
    end else w = fin;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    rd_ack <= 1'b0;
    wr_ack <= 1'b0;
    if (rd_req && !rd_ack && !stall) begin
      rd_ack  <= 1'b1;
      rd_data <= dev_word(rd_cnt - base);
      rd_cnt  <= rd_cnt + 1;
    end
    if (wr_req && !wr_ack) begin
      wr_ack <= 1'b1;
      wr_cnt <= wr_cnt + 1;
      if (wr_data != 16'h00F0) bad_wr <= bad_wr + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // method, cfg, nbusy, b5lo, b5hi, final word, result(1 ok 2 fail 3 tmo), exit writes, reads
  typedef struct packed {
    logic m; logic c; logic [7:0] nb; logic [7:0] lo; logic [7:0] hi;
    logic [15:0] fw; logic [1:0] res; logic ex; logic [7:0] nrd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd3,   8'd255, 8'd0,   16'h00A5, 2'd1, 1'b0, 8'd4},
    '{1'b0, 1'b1, 8'd2,   8'd255, 8'd0,   16'h0080, 2'd1, 1'b1, 8'd3},
    '{1'b1, 1'b0, 8'd4,   8'd255, 8'd0,   16'h00A5, 2'd1, 1'b0, 8'd6},
    '{1'b0, 1'b0, 8'd100, 8'd2,   8'd200, 16'h00A5, 2'd2, 1'b1, 8'd4},
    '{1'b0, 1'b0, 8'd3,   8'd2,   8'd2,   16'h00A5, 2'd1, 1'b0, 8'd4},
    '{1'b0, 1'b0, 8'd100, 8'd255, 8'd0,   16'h00A5, 2'd3, 1'b0, 8'd8},
    '{1'b0, 1'b1, 8'd1,   8'd255, 8'd0,   16'h00A0, 2'd2, 1'b1, 8'd2},
    '{1'b1, 1'b1, 8'd100, 8'd3,   8'd200, 16'h00A5, 2'd2, 1'b1, 8'd5},
    '{1'b1, 1'b1, 8'd1,   8'd255, 8'd0,   16'h00A5, 2'd1, 1'b1, 8'd2},
    '{1'b0, 1'b0, 8'd7,   8'd255, 8'd0,   16'h00A5, 2'd1, 1'b0, 8'd8},
    '{1'b0, 1'b0, 8'd100, 8'd7,   8'd200, 16'h00A5, 2'd3, 1'b0, 8'd8},
    '{1'b0, 1'b0, 8'd2,   8'd255, 8'd0,   16'h12A5, 2'd2, 1'b1, 8'd3}
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R4 dp auto ok";
      1: return "R5 dp exit ok";
      2: return "R6 toggle ok";
      3: return "R7 R8 confirmed fail";
      4: return "R7 transient bit5";
      5: return "R9 timeout";
      6: return "R5 bit5 after done";
      7: return "R7 R8 toggle fail";
      8: return "R6 toggle exit";
      9: return "R9 done on last read";
      10: return "R9 bit5 on last read";
      default: return "R4 word mismatch";
    endcase
  endfunction

  function automatic logic [1:0] res_code();
    return d_ok ? 2'd1 : d_fail ? 2'd2 : d_tmo ? 2'd3 : 2'd0;
  endfunction

  int wb = 0;

  task automatic launch(logic m, logic c);
    @(negedge clk);
    method = m; cfg = c;
    base = rd_cnt; wb = wr_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 400; t++) begin
      if (d_ok || d_fail || d_tmo) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {26'd0, rd_req, wr_req, busy, d_ok, d_fail, d_tmo}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {26'd0, rd_req, wr_req, busy, d_ok, d_fail, d_tmo}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      nbusy = int'(VECS[i].nb); b5lo = int'(VECS[i].lo); b5hi = int'(VECS[i].hi);
      fin = VECS[i].fw;
      launch(VECS[i].m, VECS[i].c);
      if (i == 0) chk("R2 first read without wait", {31'd0, rd_req}, 32'd1);
      wait_done();
      chk({vtag(i), " result"}, {30'd0, res_code()}, {30'd0, VECS[i].res});
      chk({vtag(i), " reads"}, rd_cnt - base, {24'd0, VECS[i].nrd});
      chk({vtag(i), " exit writes"}, wr_cnt - wb, {31'd0, VECS[i].ex});
    end
    chk("R8 exit command value", bad_wr, 0);

    // R10 result held, cleared by next start
    repeat (10) @(negedge clk);
    chk("R10 result held", {30'd0, res_code()}, 32'd2);
    nbusy = 100; b5lo = 255; b5hi = 0;
    launch(1'b0, 1'b0);
    chk("R10 result cleared on start", {30'd0, res_code()}, 32'd0);

    // R2 start while busy ignored: timeout run must keep its count
    @(negedge clk);
    method = 1'b1; cfg = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    method = 1'b0; cfg = 1'b0;
    wait_done();
    chk("R2 start while busy result", {30'd0, res_code()}, 32'd3);
    chk("R2 start while busy reads", rd_cnt - base, MR);

    // R3 read request held while stalled
    stall = 1'b1;
    nbusy = 0; fin = EXPW;
    launch(1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R3 request held under stall", {30'd0, rd_req, busy}, 32'd3);
    chk("R3 no read while stalled", rd_cnt - base, 0);
    stall = 1'b0;
    wait_done();
    chk("R3 result after stall", {30'd0, res_code()}, 32'd1);
    chk("R3 single read after stall", rd_cnt - base, 1);

    // R1 reset mid-operation
    nbusy = 100;
    launch(1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-poll", {26'd0, rd_req, wr_req, busy, d_ok, d_fail, d_tmo}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule